// File: doc/BRIEF.md
# Timekeeper SPI Register Port

This block is the serial front end of a small timekeeping peripheral. A host talks to it as an SPI master. Chip select is active high and the clock idles low. Data moves MSB first. The slave changes MISO on the rising (leading) SCLK edge, and both sides sample on the falling (trailing) edge. Each transaction starts with one command byte. Bit 7 of that byte picks the direction (1 = write, 0 = read), and bits 6:0 give the starting register address. Every data byte that follows moves one register, and the address then advances by one.

The block stores the control byte, the status byte, the charger configuration byte and a scratch RAM. The fifteen clock and alarm bytes at addresses 0x00 to 0x0E live in the timekeeping core. For those bytes the block gives the core an address, write data, a write strobe and a read strobe, and it takes back the core's read data. The SPI pins are brought into the system clock domain through synchronizers, so SCLK must run well below the system clock.

Top module: `tkspi_regif`

## Requirements
- R1: A command byte with bit 7 = 1 writes the data bytes that follow. A command byte with bit 7 = 0 reads them. Bits 6:0 are the start address. A byte written to scratch RAM reads back unchanged.
- R2: After each data byte the address advances by one, so a single burst can cover consecutive registers.
- R3: The scratch RAM spans 0x20 to 0x7F. When a burst moves past 0x7F, the address wraps to 0x20.
- R4: The control byte is at 0x0F. Its bits 5:3 always read as 0. Bit 7 drives the `osc_off` output (1 = oscillator disabled).
- R5: The status byte is at 0x10. Its bits 7:2 always read as 0. A pulse on `alarm_hit[n]` sets status bit n. A status write loads bits 1:0, and a set in the same cycle takes priority.
- R6: While control bit 6 (write protect) is 1, writes to every address other than 0x0F are ignored, and `tk_wr_stb` stays low. Writes to the control byte are still accepted.
- R7: Addresses 0x00 to 0x0E go to the core. A write pulses `tk_wr_stb` with `tk_addr` and `tk_wdata`. A read pulses `tk_rd_stb` and returns `tk_rdata`. The charger byte at 0x11 is plain storage. Addresses 0x12 to 0x1F read as 0x00 and ignore writes.
- R8: Dropping chip select discards any partial byte, holds MISO low and restarts framing. The next byte after chip select rises again is a command byte.
- R9: After reset the control byte is 0x00, `osc_off` is 0, MISO is 0 and no strobe is active.
- R10: Read data leaves MISO MSB first. MISO changes only after a leading SCLK edge, or when chip select drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, idles low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| tk_addr | output | 7 | Register address presented to the core |
| tk_wdata | output | 8 | Write data for the core |
| tk_wr_stb | output | 1 | One-cycle write strobe for 0x00 to 0x0E |
| tk_rd_stb | output | 1 | One-cycle read strobe for 0x00 to 0x0E |
| tk_rdata | input | 8 | Core read data for `tk_addr` |
| alarm_hit | input | 2 | Alarm match pulses that set the status bits |
| osc_off | output | 1 | Oscillator disable, from control bit 7 |

## Verification
The bench uses the default parameters: the RAM starts at 0x20 and holds 96 bytes, and there are two synchronizer stages. With these values the RAM ends exactly at the top of the 7-bit address space, so the wrap from 0x7F to 0x20 can be reached and every command-byte address decodes to a real region. SCLK runs at one sixteenth of the system clock. At that rate the synchronizer latency plus the one-cycle fetch of read data still fit inside half an SCLK period.

// File: rtl/tkspi_pkg.sv
// Shared types and helpers for the timekeeper SPI register port.
// Assumes a 7-bit register address taken from bits 6:0 of the command byte.
package tkspi_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // Fixed register locations that other logic depends on
    localparam int TK_LAST   = 'h0E;
    localparam int CTRL_ADDR = 'h0F;
    localparam int STAT_ADDR = 'h10;
    localparam int TRKL_ADDR = 'h11;

    // Control bit positions and the readable bit mask
    localparam int CTRL_OSC_BIT = 7;
    localparam int CTRL_WP_BIT  = 6;
    localparam data_t CTRL_MASK = 8'hC7;

    typedef enum logic [2:0] {
        RG_TK,
        RG_CTRL,
        RG_STAT,
        RG_TRKL,
        RG_RAM,
        RG_NONE
    } region_e;

    // Classify an address into its storage region
    function automatic region_e decode_region(addr_t a, int ram_base, int ram_depth);
        int ai;
        ai = int'(a);
        if (ai <= TK_LAST)                                   return RG_TK;
        else if (ai == CTRL_ADDR)                            return RG_CTRL;
        else if (ai == STAT_ADDR)                            return RG_STAT;
        else if (ai == TRKL_ADDR)                            return RG_TRKL;
        else if (ai >= ram_base && ai < ram_base + ram_depth) return RG_RAM;
        else                                                 return RG_NONE;
    endfunction

    // Step the burst address, wrapping at the end of the RAM
    function automatic addr_t step_addr(addr_t a, int ram_base, int ram_depth);
        if (int'(a) == ram_base + ram_depth - 1) return addr_t'(ram_base);
        else                                     return a + addr_t'(1);
    endfunction

endpackage

// File: rtl/tkspi_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each input bit is independent (no bus coherency needed).
module tkspi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move the bundle one stage closer to clk
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else if (s == 0) stg[s] <= d;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tkspi_shift.sv
// SPI bit engine: synchronizes the pins, finds SCLK edges, assembles
// received bytes and shifts transmit bytes out MSB first.
// Assumes SCLK idles low, CPHA=1, and SCLK well below clk.
module tkspi_shift
    import tkspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk,
    input  logic  cs,
    input  logic  mosi,
    input  logic  load_en,
    input  data_t load_byte,
    output logic  miso,
    output logic  byte_done,
    output data_t rx_byte,
    output logic  first_byte,
    output logic  cs_act,
    output logic  lead_edge
);

    localparam int CNT_W = $clog2(DATA_W);

    logic [2:0]       pins_s;
    logic             sclk_s, mosi_s, sclk_prev;
    logic             trail_edge;
    logic [CNT_W-1:0] bit_cnt;
    data_t            tx_q;

    tkspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, cs, mosi}),
        .q    (pins_s)
    );

    assign sclk_s     = pins_s[2];
    assign cs_act     = pins_s[1];
    assign mosi_s     = pins_s[0];
    assign lead_edge  = cs_act &  sclk_s & ~sclk_prev;
    assign trail_edge = cs_act & ~sclk_s &  sclk_prev;

    // Purpose: remember the last synchronized SCLK level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    // Purpose: shift bits in on trailing edges, out on leading edges
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt    <= '0;
            rx_byte    <= '0;
            tx_q       <= '0;
            miso       <= 1'b0;
            byte_done  <= 1'b0;
            first_byte <= 1'b1;
        end else begin
            byte_done <= 1'b0;
            if (byte_done) first_byte <= 1'b0;
            if (lead_edge) begin
                miso <= tx_q[DATA_W-1];
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            end else if (load_en) begin
                tx_q <= load_byte;
            end
            if (trail_edge) begin
                rx_byte <= {rx_byte[DATA_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == CNT_W'(DATA_W-1)) byte_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tkspi_regbank.sv
// Local register storage: control, status, charger byte and scratch RAM.
// Applies write protect and the read-as-zero masks, and muxes read data,
// taking the clock/alarm bytes from the timekeeping core.
module tkspi_regbank
    import tkspi_pkg::*;
#(
    parameter int    RAM_BASE  = 'h20,
    parameter int    RAM_DEPTH = 96,
    parameter data_t CTRL_RST  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  addr_t      addr,
    input  logic       wr_req,
    input  logic       rd_req,
    input  data_t      wdata,
    input  data_t      tk_rdata,
    input  logic [1:0] alarm_hit,
    output data_t      rd_data,
    output logic       tk_wr_ok,
    output logic       tk_rd_hit,
    output logic       wp,
    output logic       osc_off
);

    localparam int RAM_IW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    region_e           region;
    logic              wr_ok;
    data_t             ctrl_q, trkl_q;
    logic [1:0]        stat_q;
    data_t             ram [RAM_DEPTH];
    addr_t             ram_off;
    logic [RAM_IW-1:0] ram_idx;

    assign region    = decode_region(addr, RAM_BASE, RAM_DEPTH);
    assign wp        = ctrl_q[CTRL_WP_BIT];
    assign osc_off   = ctrl_q[CTRL_OSC_BIT];
    assign wr_ok     = wr_req && (region != RG_NONE) && (region == RG_CTRL || !wp);
    assign tk_wr_ok  = wr_ok && (region == RG_TK);
    assign tk_rd_hit = rd_req && (region == RG_TK);
    assign ram_off   = addr - addr_t'(RAM_BASE);
    assign ram_idx   = ram_off[RAM_IW-1:0];

    // Purpose: hold the control and charger bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST & CTRL_MASK;
            trkl_q <= '0;
        end else if (wr_ok) begin
            if (region == RG_CTRL) ctrl_q <= wdata & CTRL_MASK;
            if (region == RG_TRKL) trkl_q <= wdata;
        end
    end

    // Purpose: alarm flags, set by the core, loaded by host writes
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else if (wr_ok && region == RG_STAT) stat_q <= wdata[1:0] | alarm_hit;
        else stat_q <= stat_q | alarm_hit;
    end

    // Purpose: scratch RAM write port
    always_ff @(posedge clk) begin
        if (wr_ok && region == RG_RAM) ram[ram_idx] <= wdata;
    end

    // Purpose: select the byte for the current address
    always_comb begin
        unique case (region)
            RG_TK:   rd_data = tk_rdata;
            RG_CTRL: rd_data = ctrl_q;
            RG_STAT: rd_data = {6'b0, stat_q};
            RG_TRKL: rd_data = trkl_q;
            RG_RAM:  rd_data = ram[ram_idx];
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tkspi_regif.sv
// Top of the timekeeper SPI register port. Turns received bytes into a
// command (direction + start address) and a stream of register accesses
// with an auto-incrementing address. Read data is fetched one cycle after
// the byte boundary, ahead of the next leading SCLK edge.
// Assumes SCLK half-period of at least SYNC_STAGES + 4 clk cycles.
module tkspi_regif
    import tkspi_pkg::*;
#(
    parameter int    RAM_BASE    = 'h20,
    parameter int    RAM_DEPTH   = 96,
    parameter int    SYNC_STAGES = 2,
    parameter data_t CTRL_RST    = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic [6:0]  tk_addr,
    output logic [7:0]  tk_wdata,
    output logic        tk_wr_stb,
    output logic        tk_rd_stb,
    input  logic [7:0]  tk_rdata,
    input  logic [1:0]  alarm_hit,
    output logic        osc_off
);

    logic  byte_done, first_byte, cs_act, lead_edge;
    data_t rx_byte, rd_data;
    addr_t addr_q;
    logic  wr_mode_q, fetch_q, wr_req, wp;

    tkspi_shift #(.SYNC_STAGES(SYNC_STAGES)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs        (spi_cs),
        .mosi      (spi_mosi),
        .load_en   (fetch_q),
        .load_byte (rd_data),
        .miso      (spi_miso),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .first_byte(first_byte),
        .cs_act    (cs_act),
        .lead_edge (lead_edge)
    );

    assign wr_req = byte_done && !first_byte && wr_mode_q;

    // Purpose: command decode, burst address stepping and fetch scheduling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wr_mode_q <= 1'b0;
            fetch_q   <= 1'b0;
        end else if (!cs_act) begin
            wr_mode_q <= 1'b0;
            fetch_q   <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            if (byte_done) begin
                if (first_byte) begin
                    addr_q    <= rx_byte[ADDR_W-1:0];
                    wr_mode_q <= rx_byte[DATA_W-1];
                    fetch_q   <= !rx_byte[DATA_W-1];
                end else begin
                    addr_q  <= step_addr(addr_q, RAM_BASE, RAM_DEPTH);
                    fetch_q <= !wr_mode_q;
                end
            end
        end
    end

    tkspi_regbank #(
        .RAM_BASE (RAM_BASE),
        .RAM_DEPTH(RAM_DEPTH),
        .CTRL_RST (CTRL_RST)
    ) i_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr_q),
        .wr_req   (wr_req),
        .rd_req   (fetch_q),
        .wdata    (rx_byte),
        .tk_rdata (tk_rdata),
        .alarm_hit(alarm_hit),
        .rd_data  (rd_data),
        .tk_wr_ok (tk_wr_stb),
        .tk_rd_hit(tk_rd_stb),
        .wp       (wp),
        .osc_off  (osc_off)
    );

    assign tk_addr  = addr_q;
    assign tk_wdata = rx_byte;

endmodule

// File: rtl/tkspi_regif_chk.sv
// Protocol checks for tkspi_regif, attached to every instance by bind.
// Assumes it sees the top's chip-select, edge and protect signals.
module tkspi_regif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input logic       lead_edge,
    input logic       wp,
    input logic       spi_miso,
    input logic [6:0] tk_addr,
    input logic       tk_wr_stb,
    input logic       tk_rd_stb
);

    // R6
    wp_blocks_core_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tk_wr_stb |-> !wp);

    // R7
    core_write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tk_wr_stb |-> (tk_addr <= 7'h0E));

    // R7
    core_read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tk_rd_stb |-> (tk_addr <= 7'h0E));

    // R7
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tk_wr_stb && tk_rd_stb));

    // R8
    miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);

    // R10
    miso_leading_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso != $past(spi_miso)) |-> ($past(lead_edge) || !$past(cs_act)));

endmodule

bind tkspi_regif tkspi_regif_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .lead_edge(lead_edge),
    .wp       (wp),
    .spi_miso (spi_miso),
    .tk_addr  (tk_addr),
    .tk_wr_stb(tk_wr_stb),
    .tk_rd_stb(tk_rd_stb)
);

// File: tb/test_tkspi_regif.sv
// Directed bench for tkspi_regif: an SPI master model and a small core model.
module test_tkspi_regif;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
    logic       miso;
    logic [6:0] tk_addr;
    logic [7:0] tk_wdata, tk_rdata;
    logic       tk_wr_stb, tk_rd_stb;
    logic [1:0] alarm_hit = 2'b00;
    logic       osc_off;

    int vectors = 0;
    int fails   = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic [7:0] tk_mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    tkspi_regif i_tkspi_regif (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(sclk), .spi_cs(cs), .spi_mosi(mosi), .spi_miso(miso),
        .tk_addr(tk_addr), .tk_wdata(tk_wdata),
        .tk_wr_stb(tk_wr_stb), .tk_rd_stb(tk_rd_stb),
        .tk_rdata(tk_rdata), .alarm_hit(alarm_hit), .osc_off(osc_off)
    );

    // Core model: fifteen clock/alarm bytes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) tk_mem[i] <= 8'(i * 17 + 3);
        end else if (tk_wr_stb) begin
            tk_mem[tk_addr[3:0]] <= tk_wdata;
        end
    end
    assign tk_rdata = (tk_addr < 7'd15) ? tk_mem[tk_addr[3:0]] : 8'h00;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits of tx MSB first; capture MISO before each trailing edge
    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            mosi = tx[i];
            sclk = 1'b1;
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b0;
            wait_clk(HALF - 1);
        end
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs = 1'b1;
        wait_clk(4);
    endtask

    task automatic cs_off();
        wait_clk(4);
        cs = 1'b0;
        wait_clk(6);
    endtask

    task automatic spi_write(input logic [6:0] a, input int n);
        logic [7:0] junk;
        cs_on();
        spi_bits({1'b1, a}, 8, junk);
        for (int k = 0; k < n; k++) spi_bits(wbuf[k], 8, junk);
        cs_off();
    endtask

    task automatic spi_read(input logic [6:0] a, input int n);
        logic [7:0] junk;
        cs_on();
        spi_bits({1'b0, a}, 8, junk);
        for (int k = 0; k < n; k++) spi_bits(8'h00, 8, rbuf[k]);
        cs_off();
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] d);
        wbuf[0] = d;
        spi_write(a, 1);
    endtask

    task automatic t_reset();
        chk("R9 osc_off", {7'b0, osc_off}, 8'h00);
        chk("R9 miso", {7'b0, miso}, 8'h00);
        chk("R9 strobes", {6'b0, tk_wr_stb, tk_rd_stb}, 8'h00);
        spi_read(7'h0F, 1);
        chk("R9 control", rbuf[0], 8'h00);
    endtask

    task automatic t_ram_burst();
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        spi_write(7'h20, 3);
        spi_read(7'h20, 3);
        chk("R1 ram byte0", rbuf[0], 8'hA1);
        chk("R2 ram byte1", rbuf[1], 8'hB2);
        chk("R10 ram byte2 msb-first", rbuf[2], 8'hC3);
    endtask

    task automatic t_wrap();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        spi_write(7'h7F, 2);
        spi_read(7'h7E, 3);
        chk("R3 0x7F", rbuf[1], 8'h11);
        chk("R3 wrap to 0x20", rbuf[2], 8'h22);
    endtask

    task automatic t_core();
        spi_read(7'h00, 2);
        chk("R7 core read 0x00", rbuf[0], 8'h03);
        chk("R7 core read 0x01", rbuf[1], 8'h14);
        for (int k = 0; k < 7; k++) wbuf[k] = 8'(8'h40 + k);
        spi_write(7'h00, 7);
        chk("R7 core model 0x06", tk_mem[6], 8'h46);
        spi_read(7'h00, 7);
        for (int k = 0; k < 7; k++) chk("R2 core burst", rbuf[k], 8'(8'h40 + k));
    endtask

    task automatic t_ctrl();
        wr1(7'h0F, 8'hBF);
        chk("R4 osc_off", {7'b0, osc_off}, 8'h01);
        spi_read(7'h0F, 1);
        chk("R4 control masked", rbuf[0], 8'h87);
        wr1(7'h0F, 8'h00);
        chk("R4 osc_off clear", {7'b0, osc_off}, 8'h00);
    endtask

    task automatic t_status();
        @(negedge clk); alarm_hit = 2'b10;
        @(negedge clk); alarm_hit = 2'b00;
        spi_read(7'h10, 1);
        chk("R5 alarm set", rbuf[0], 8'h02);
        wr1(7'h10, 8'hFF);
        spi_read(7'h10, 1);
        chk("R5 status masked", rbuf[0], 8'h03);
        wr1(7'h10, 8'h00);
        spi_read(7'h10, 1);
        chk("R5 status cleared", rbuf[0], 8'h00);
    endtask

    task automatic t_protect();
        wr1(7'h11, 8'h5A);
        wr1(7'h30, 8'h33);
        wr1(7'h0F, 8'h40);
        wr1(7'h11, 8'h00);
        wr1(7'h30, 8'h77);
        wr1(7'h02, 8'hEE);
        spi_read(7'h11, 1);
        chk("R6 trickle kept", rbuf[0], 8'h5A);
        spi_read(7'h30, 1);
        chk("R6 ram kept", rbuf[0], 8'h33);
        spi_read(7'h02, 1);
        chk("R6 core kept", rbuf[0], 8'h42);
        spi_read(7'h0F, 1);
        chk("R6 control readable", rbuf[0], 8'h40);
        wr1(7'h0F, 8'h00);
        wr1(7'h11, 8'hC6);
        spi_read(7'h11, 1);
        chk("R6 unlocked write", rbuf[0], 8'hC6);
    endtask

    task automatic t_unused();
        wr1(7'h15, 8'h99);
        spi_read(7'h11, 3);
        chk("R7 trickle", rbuf[0], 8'hC6);
        chk("R7 0x12 zero", rbuf[1], 8'h00);
        chk("R7 0x13 zero", rbuf[2], 8'h00);
        spi_read(7'h15, 1);
        chk("R7 0x15 zero", rbuf[0], 8'h00);
        wbuf[0] = 8'h44; wbuf[1] = 8'h55;
        spi_write(7'h1F, 2);
        spi_read(7'h1F, 2);
        chk("R7 0x1F zero", rbuf[0], 8'h00);
        chk("R7 burst into ram", rbuf[1], 8'h55);
    endtask

    task automatic t_abort();
        logic [7:0] junk;
        cs_on();
        spi_bits(8'hA1, 8, junk);
        spi_bits(8'h12, 8, junk);
        spi_bits(8'hFF, 4, junk);
        cs_off();
        cs_on();
        spi_bits(8'h5A, 3, junk);
        cs_off();
        chk("R8 miso low", {7'b0, miso}, 8'h00);
        spi_read(7'h20, 3);
        chk("R8 ram 0x20", rbuf[0], 8'h55);
        chk("R8 full byte kept", rbuf[1], 8'h12);
        chk("R8 partial dropped", rbuf[2], 8'hC3);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_ram_burst();
        t_wrap();
        t_core();
        t_ctrl();
        t_status();
        t_protect();
        t_unused();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule